// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a register-controlled SPI master that runs a counted transfer. Software programs a frame count, a baud divider, a communication mode and the clock and bit-order options while the block is disabled. It then enables the block, may preload transmit frames, and sets a start bit. The engine clocks exactly the programmed number of frames, raises an end-of-transfer flag and drops the start bit by itself. Chip selects are driven outside the block.

A running transfer can be paused at a frame boundary by a suspend request. With automatic suspend enabled, the engine also pauses on its own when the receive queue is full. Without automatic suspend, a full receive queue drops the incoming frame and sets an overrun flag. Setting start again resumes the remaining frames. Status flags are cleared by writing ones.

Register map (3-bit word address): 0 control, 1 configuration, 2 frame count, 3 status (read), 4 flag clear (write), 5 transmit data (write), 6 receive data (read, pops one frame).

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, sclk is low, and the control, configuration and status registers read 0. The one exception is status bit 5 (transmit space), which reads 1.
- R2: A write to configuration (bits [2:0] divider, [4:3] mode, 5 polarity, 6 phase, 7 LSB-first) takes effect only while control bit 0 (enable) is clear. While enabled, the register keeps its old value.
- R3: Setting control bit 1 (start) runs exactly the count in register 2, FW bits per frame. Then status bit 0 (end-of-transfer) sets, and start, readable as status bit 6, clears itself.
- R4: Each sclk half period lasts 2^divider kernel clock cycles, giving divisors 2 to 256.
- R5: sclk idles at the polarity bit. With phase 0, data is captured on leading edges; with phase 1, on trailing edges. Frames go MSB first unless LSB-first is set.
- R6: Full duplex (mode 0) sends transmit-queue frames and stores each received frame in the receive queue in arrival order.
- R7: In transmit-only mode (mode 1), miso is ignored and nothing enters the receive queue.
- R8: In receive-only mode (mode 2), mosi holds ones during every frame, no transmit data is needed, and received frames are stored.
- R9: In half duplex (mode 3), control bit 4 selects the direction. When it is 0, mosi_oe is low and frames are received. When it is 1, mosi_oe is high and frames are sent with nothing stored.
- R10: Setting control bit 2 (suspend request) during a transfer stops after the current frame and sets status bit 3, and start clears. A new start resumes and finishes the remaining frames.
- R11: With control bit 3 (auto-suspend) set, a full receive queue in a receiving mode suspends the transfer before the next frame. Without it, status bit 2 (overrun) sets and extra frames are dropped.
- R12: Status bit 1 (transmission filled) sets when the number of frames written to the transmit register since the last transfer end equals the frame count.
- R13: Writing ones to register 4 clears the matching status bits 0 to 3.
- R14: Setting start while enable is clear has no effect, and no sclk edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops on receive data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data line |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default build: 8-bit frames, a 4-entry queue in each direction, a 3-bit divider field and a 16-bit frame count. Because the queues hold only four frames, a six-frame receive transfer fills the receive queue. This brings both automatic suspend and overrun into reach, and shows that transmit refill during a transfer works. The 3-bit divider lets the bench measure half periods of 2, 4 and 8 cycles and run all four polarity and phase combinations in loopback.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'd0,
    MODE_TX_ONLY = 2'd1,
    MODE_RX_ONLY = 2'd2,
    MODE_HALF    = 2'd3
  } xfer_mode_e;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd5;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd6;

  localparam int CT_EN   = 0;
  localparam int CT_GO   = 1;
  localparam int CT_SREQ = 2;
  localparam int CT_AUTO = 3;
  localparam int CT_HDIR = 4;

  localparam int ST_EOT  = 0;
  localparam int ST_TXF  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_SUSP = 3;
  localparam int ST_RXAV = 4;
  localparam int ST_TXSP = 5;
  localparam int ST_RUN  = 6;

endpackage

// File: rtl/spi_frame_queue.sv
module spi_frame_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = bump(wp_q);
      if (do_pop)  rp_n = bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + CW'(1);
        2'b01:   cnt_n = cnt_q - CW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= wdata;
  end

  p_queue_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int FW    = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic [FW-1:0]    tx_word,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [FW-1:0]    rx_word
);
  localparam int HC_W = (1 << DIV_W);
  localparam int EC_W = $clog2(2 * FW) + 1;
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * FW);

  logic            busy_q, busy_n, done_q, done_n, sclk_q, sclk_n, mosi_q, mosi_n;
  logic [HC_W-1:0] hcnt_q, hcnt_n, half_lim;
  logic [EC_W-1:0] ecnt_q, ecnt_n, e_nxt;
  logic [FW-1:0]   txsr_q, txsr_n, rxsr_q, rxsr_n;
  logic            tick, odd, do_sample, do_emit;

  assign half_lim = (HC_W'(1) << div) - HC_W'(1);
  assign tick     = busy_q && (hcnt_q == half_lim);
  assign e_nxt    = ecnt_q + EC_W'(1);
  assign odd      = e_nxt[0];
  assign do_sample = cpha ? !odd : odd;
  assign do_emit   = cpha ? odd : (!odd && (e_nxt != LAST_EDGE));

  function automatic logic head_bit(input logic [FW-1:0] w, input logic lsb);
    return lsb ? w[0] : w[FW-1];
  endfunction

  function automatic logic [FW-1:0] drop_head(input logic [FW-1:0] w, input logic lsb);
    return lsb ? (w >> 1) : (w << 1);
  endfunction

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    sclk_n = sclk_q;
    mosi_n = mosi_q;
    hcnt_n = hcnt_q;
    ecnt_n = ecnt_q;
    txsr_n = txsr_q;
    rxsr_n = rxsr_q;
    if (clr) begin
      busy_n = 1'b0;
      sclk_n = cpol;
      mosi_n = 1'b1;
    end else if (!busy_q) begin
      sclk_n = cpol;
      if (go) begin
        busy_n = 1'b1;
        hcnt_n = '0;
        ecnt_n = '0;
        if (!cpha) begin
          mosi_n = head_bit(tx_word, lsb_first);
          txsr_n = drop_head(tx_word, lsb_first);
        end else begin
          txsr_n = tx_word;
        end
      end
    end else if (tick) begin
      hcnt_n = '0;
      sclk_n = !sclk_q;
      ecnt_n = e_nxt;
      if (do_sample)
        rxsr_n = lsb_first ? {miso, rxsr_q[FW-1:1]} : {rxsr_q[FW-2:0], miso};
      if (do_emit) begin
        mosi_n = head_bit(txsr_q, lsb_first);
        txsr_n = drop_head(txsr_q, lsb_first);
      end
      if (e_nxt == LAST_EDGE) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end else begin
      hcnt_n = hcnt_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b1;
      hcnt_q <= '0;
      ecnt_q <= '0;
      txsr_q <= '0;
      rxsr_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      sclk_q <= sclk_n;
      mosi_q <= mosi_n;
      hcnt_q <= hcnt_n;
      ecnt_q <= ecnt_n;
      txsr_q <= txsr_n;
      rxsr_q <= rxsr_n;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rxsr_q;

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  p_sclk_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && hcnt_q != '0) |-> $stable(sclk_q));

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q) && !clr && $stable(cpol)) |-> (sclk_q == cpol));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int FW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 3,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  output logic        mosi_oe,
  input  logic        miso
);
  localparam int PC_W  = CNT_W + 1;
  localparam int CFG_W = DIV_W + 5;

  // reset: asynchronous assertion, synchronous release
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  logic arst_n;
  assign arst_n = rst_s_q;

  // register state
  logic             en_q, en_n, start_q, start_n, sreq_q, sreq_n;
  logic             auto_q, auto_n, hdir_q, hdir_n, inx_q, inx_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [1:0]       mode_q, mode_n;
  logic             cpol_q, cpol_n, cpha_q, cpha_n, lsb_q, lsb_n;
  logic [CNT_W-1:0] size_q, size_n, left_q, left_n;
  logic [PC_W-1:0]  pcnt_q, pcnt_n;
  logic             eot_q, eot_n, txf_q, txf_n, ovr_q, ovr_n, susp_q, susp_n;

  // queues and engine
  logic          txq_empty, txq_full, rxq_empty, rxq_full, txq_pop, rxq_push, rxq_pop, tx_push;
  logic [FW-1:0] txq_head, rxq_head, eng_tx, eng_rx;
  logic          eng_busy, eng_done, eng_go, qclr;

  logic wr_ctrl, wr_cfg, wr_size, wr_clr, wr_txd;
  logic tx_act, rx_act, idle_pt, eot_ev, susp_ev;
  xfer_mode_e mode_e;

  assign mode_e  = xfer_mode_e'(mode_q);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_cfg  = reg_we && (reg_addr == A_CFG);
  assign wr_size = reg_we && (reg_addr == A_SIZE);
  assign wr_clr  = reg_we && (reg_addr == A_CLR);
  assign wr_txd  = reg_we && (reg_addr == A_TXD);

  always_comb begin
    case (mode_e)
      MODE_DUPLEX:  begin tx_act = 1'b1;    rx_act = 1'b1;    end
      MODE_TX_ONLY: begin tx_act = 1'b1;    rx_act = 1'b0;    end
      MODE_RX_ONLY: begin tx_act = 1'b0;    rx_act = 1'b1;    end
      default:      begin tx_act = hdir_q;  rx_act = !hdir_q; end
    endcase
  end

  // frame scheduling
  assign idle_pt = start_q && !eng_busy && !eng_done;
  assign eot_ev  = idle_pt && inx_q && (left_q == '0);
  assign susp_ev = idle_pt && (left_q != '0) &&
                   (sreq_q || (auto_q && rx_act && rxq_full));
  assign eng_go  = idle_pt && (left_q != '0) && !susp_ev && (!tx_act || !txq_empty);
  assign txq_pop = eng_go && tx_act;
  assign eng_tx  = tx_act ? txq_head : {FW{1'b1}};
  assign rxq_push = eng_done && rx_act && !rxq_full;
  assign tx_push  = wr_txd && en_q && !txq_full;
  assign rxq_pop  = reg_re && (reg_addr == A_RXD) && !rxq_empty;
  assign qclr     = !en_q;

  always_comb begin
    en_n = en_q; start_n = start_q; sreq_n = sreq_q; auto_n = auto_q; hdir_n = hdir_q;
    inx_n = inx_q; div_n = div_q; mode_n = mode_q; cpol_n = cpol_q; cpha_n = cpha_q;
    lsb_n = lsb_q; size_n = size_q; left_n = left_q; pcnt_n = pcnt_q;
    eot_n = eot_q; txf_n = txf_q; ovr_n = ovr_q; susp_n = susp_q;

    if (wr_ctrl) begin
      en_n   = reg_wdata[CT_EN];
      auto_n = reg_wdata[CT_AUTO];
      hdir_n = reg_wdata[CT_HDIR];
      if (reg_wdata[CT_GO] && en_q && !start_q) begin
        start_n = 1'b1;
        if (!inx_q) begin
          left_n = size_q;
          inx_n  = 1'b1;
        end
      end
      if (reg_wdata[CT_SREQ] && start_q) sreq_n = 1'b1;
    end
    if (wr_cfg && !en_q) begin
      div_n  = reg_wdata[DIV_W-1:0];
      mode_n = reg_wdata[DIV_W+1:DIV_W];
      cpol_n = reg_wdata[DIV_W+2];
      cpha_n = reg_wdata[DIV_W+3];
      lsb_n  = reg_wdata[DIV_W+4];
    end
    if (wr_size && !start_q) size_n = reg_wdata[CNT_W-1:0];
    if (wr_clr) begin
      if (reg_wdata[ST_EOT])  eot_n  = 1'b0;
      if (reg_wdata[ST_TXF])  txf_n  = 1'b0;
      if (reg_wdata[ST_OVR])  ovr_n  = 1'b0;
      if (reg_wdata[ST_SUSP]) susp_n = 1'b0;
    end
    if (tx_push) begin
      pcnt_n = pcnt_q + PC_W'(1);
      if (pcnt_n == {1'b0, size_q}) txf_n = 1'b1;
    end
    if (eng_done) begin
      if (left_q != '0) left_n = left_q - CNT_W'(1);
      if (rx_act && rxq_full) ovr_n = 1'b1;
    end
    if (eot_ev) begin
      start_n = 1'b0;
      sreq_n  = 1'b0;
      inx_n   = 1'b0;
      eot_n   = 1'b1;
      pcnt_n  = '0;
    end
    if (susp_ev) begin
      start_n = 1'b0;
      sreq_n  = 1'b0;
      susp_n  = 1'b1;
    end
    if (!en_q) begin
      start_n = 1'b0;
      sreq_n  = 1'b0;
      inx_n   = 1'b0;
      left_n  = '0;
      pcnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q <= 1'b0; start_q <= 1'b0; sreq_q <= 1'b0; auto_q <= 1'b0; hdir_q <= 1'b0;
      inx_q <= 1'b0; div_q <= '0; mode_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      lsb_q <= 1'b0; size_q <= '0; left_q <= '0; pcnt_q <= '0;
      eot_q <= 1'b0; txf_q <= 1'b0; ovr_q <= 1'b0; susp_q <= 1'b0;
    end else begin
      en_q <= en_n; start_q <= start_n; sreq_q <= sreq_n; auto_q <= auto_n; hdir_q <= hdir_n;
      inx_q <= inx_n; div_q <= div_n; mode_q <= mode_n; cpol_q <= cpol_n; cpha_q <= cpha_n;
      lsb_q <= lsb_n; size_q <= size_n; left_q <= left_n; pcnt_q <= pcnt_n;
      eot_q <= eot_n; txf_q <= txf_n; ovr_q <= ovr_n; susp_q <= susp_n;
    end
  end

  spi_frame_queue #(.W(FW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(arst_n), .clr(qclr), .push(tx_push), .wdata(reg_wdata[FW-1:0]),
    .pop(txq_pop), .rdata(txq_head), .empty(txq_empty), .full(txq_full));

  spi_frame_queue #(.W(FW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(arst_n), .clr(qclr), .push(rxq_push), .wdata(eng_rx),
    .pop(rxq_pop), .rdata(rxq_head), .empty(rxq_empty), .full(rxq_full));

  spi_bit_engine #(.FW(FW), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(arst_n), .clr(qclr), .go(eng_go), .tx_word(eng_tx), .div(div_q),
    .cpol(cpol_q), .cpha(cpha_q), .lsb_first(lsb_q), .miso(miso), .sclk(sclk),
    .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx_word(eng_rx));

  assign mosi_oe = !((mode_e == MODE_HALF) && !hdir_q);

  logic [CFG_W-1:0] cfg_vec;
  assign cfg_vec = {lsb_q, cpha_q, cpol_q, mode_q, div_q};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CT_EN]   = en_q;
        reg_rdata[CT_GO]   = start_q;
        reg_rdata[CT_SREQ] = sreq_q;
        reg_rdata[CT_AUTO] = auto_q;
        reg_rdata[CT_HDIR] = hdir_q;
      end
      A_CFG:  reg_rdata[CFG_W-1:0] = cfg_vec;
      A_SIZE: reg_rdata[CNT_W-1:0] = size_q;
      A_STAT: begin
        reg_rdata[ST_EOT]  = eot_q;
        reg_rdata[ST_TXF]  = txf_q;
        reg_rdata[ST_OVR]  = ovr_q;
        reg_rdata[ST_SUSP] = susp_q;
        reg_rdata[ST_RXAV] = !rxq_empty;
        reg_rdata[ST_TXSP] = !txq_full;
        reg_rdata[ST_RUN]  = start_q;
      end
      A_RXD:  reg_rdata[FW-1:0] = rxq_head;
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{reg_wdata, reg_re};

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (en_q && $past(en_q)) |-> $stable(cfg_vec));

  p_eot_stops_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(eot_q) |-> !start_q);

  p_susp_boundary_r10: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(susp_q) |-> (!eng_busy && !start_q));

  p_ovr_when_full_r11: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ovr_q) |-> $past(rxq_full));

  p_no_go_disabled_r14: assert property (@(posedge clk) disable iff (!arst_n)
    !en_q |=> !eng_busy);

endmodule

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;
  logic        clk, rst_n, reg_we, reg_re, miso_inv;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sclk, mosi, mosi_oe, miso;

  int total = 0;
  int bad = 0;

  spi_xfer_master u_spi_xfer_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .mosi_oe(mosi_oe), .miso(miso));

  assign miso = mosi ^ miso_inv;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // serial monitor
  int   cyc = 0;
  int   lead_cyc = 0;
  int   half_meas = 0;
  int   cap_n = 0;
  int   edges = 0;
  logic cap_bits [0:511];
  logic m_cpol = 1'b0, m_cpha = 1'b0, sclk_prev = 1'b0;
  bit   oe_low_seen = 1'b0, oe_high_seen = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && sclk !== sclk_prev) begin
      edges = edges + 1;
      if (sclk != m_cpol) lead_cyc = cyc;
      else half_meas = cyc - lead_cyc;
      if ((m_cpha ? (sclk == m_cpol) : (sclk != m_cpol)) && cap_n < 512) begin
        cap_bits[cap_n] = mosi;
        cap_n = cap_n + 1;
      end
      if (mosi_oe) oe_high_seen = 1'b1;
      else oe_low_seen = 1'b1;
    end
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  logic [31:0] ctrl_base;
  logic [7:0]  txw [0:7];
  logic [7:0]  rxw [0:7];

  task automatic setup(input int div, input int mode, input bit cpol, input bit cpha,
                       input bit lsb, input int size, input logic [31:0] extra);
    wr(3'd0, 32'h0);
    wr(3'd1, (32'(lsb) << 7) | (32'(cpha) << 6) | (32'(cpol) << 5) | (32'(mode) << 3) | 32'(div));
    wr(3'd2, 32'(size));
    m_cpol = cpol; m_cpha = cpha;
    ctrl_base = 32'h1 | extra;
    wr(3'd0, ctrl_base);
    wr(3'd4, 32'hF);
    repeat (3) @(negedge clk);
    cap_n = 0; edges = 0; oe_low_seen = 0; oe_high_seen = 0;
  endtask

  // waits until status bit 0 (end) or bit 3 (suspend) is set
  task automatic wait_stop(output logic [31:0] st);
    int n = 0;
    st = 0;
    while (n < 20000 && st[0] == 1'b0 && st[3] == 1'b0) begin
      rd(3'd3, st);
      n++;
    end
  endtask

  // preload, start, refill until stop
  task automatic run(input int n, input bit feed, output logic [31:0] st);
    int pushed = 0;
    logic [31:0] s;
    int guard = 0;
    if (feed) while (pushed < n && pushed < 4) begin wr(3'd5, 32'(txw[pushed])); pushed++; end
    wr(3'd0, ctrl_base | 32'h2);
    s = 0;
    while (guard < 20000 && s[0] == 1'b0 && s[3] == 1'b0) begin
      rd(3'd3, s);
      if (feed && pushed < n && s[5]) begin wr(3'd5, 32'(txw[pushed])); pushed++; end
      guard++;
    end
    st = s;
  endtask

  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin rd(3'd6, d); rxw[i] = d[7:0]; end
  endtask

  function automatic int bit_errs(input int n, input bit lsb, input bit ones);
    int e = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic expb;
        expb = ones ? 1'b1 : (lsb ? txw[i][k] : txw[i][7-k]);
        if (cap_bits[i*8+k] !== expb) e++;
      end
    return e;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk(sclk == 1'b0, "R1 sclk idle", 32'(sclk), 0);
    rd(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(3'd1, d); chk(d == 0, "R1 cfg", d, 0);
    rd(3'd3, d); chk(d == 32'h20, "R1 status", d, 32'h20);
  endtask

  task automatic t_start_disabled();
    logic [31:0] d;
    edges = 0;
    wr(3'd0, 32'h2);
    repeat (40) @(negedge clk);
    rd(3'd3, d); chk(d[6] == 1'b0, "R14 start ignored", d, 0);
    chk(edges == 0, "R14 no sclk edge", 32'(edges), 0);
  endtask

  task automatic t_cfg_lock();
    logic [31:0] d;
    wr(3'd0, 32'h1);
    wr(3'd1, 32'hFF);
    rd(3'd1, d); chk(d == 0, "R2 locked while enabled", d, 0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h6A);
    rd(3'd1, d); chk(d == 32'h6A, "R2 write while disabled", d, 32'h6A);
  endtask

  task automatic t_duplex(input int div, input bit cpol, input bit cpha, input bit lsb);
    logic [31:0] st;
    txw[0] = 8'hA5; txw[1] = 8'h3C; txw[2] = 8'h81; txw[3] = 8'h5E; txw[4] = 8'h07;
    miso_inv = 1'b0;
    setup(div, 0, cpol, cpha, lsb, 5, 0);
    run(5, 1'b1, st);
    chk(st[0] == 1'b1 && st[6] == 1'b0, "R3 end set start cleared", st, 32'h1);
    chk(cap_n == 40, "R3 frame count", 32'(cap_n), 40);
    chk(bit_errs(5, lsb, 0) == 0, "R5 bit order and phase", 32'(bit_errs(5, lsb, 0)), 0);
    chk(half_meas == (1 << div), "R4 half period", 32'(half_meas), 32'(1 << div));
    chk(sclk == cpol, "R5 idle level", 32'(sclk), 32'(cpol));
    drain(4);
    chk(rxw[0] == 8'hA5 && rxw[3] == 8'h5E, "R6 loopback order", {rxw[0], rxw[3]}, 16'hA55E);
  endtask

  task automatic t_txonly();
    logic [31:0] st;
    txw[0] = 8'hC3; txw[1] = 8'h19;
    miso_inv = 1'b1;
    setup(1, 1, 0, 0, 0, 2, 0);
    run(2, 1'b1, st);
    chk(bit_errs(2, 0, 0) == 0, "R7 tx data", 32'(bit_errs(2, 0, 0)), 0);
    chk(st[4] == 1'b0, "R7 nothing stored", st, 0);
  endtask

  task automatic t_rxonly();
    logic [31:0] st;
    miso_inv = 1'b1;
    setup(0, 2, 0, 1, 0, 2, 0);
    run(2, 1'b0, st);
    chk(st[0] == 1'b1 && cap_n == 16, "R8 runs without tx data", 32'(cap_n), 16);
    chk(bit_errs(2, 0, 1) == 0, "R8 mosi ones", 32'(bit_errs(2, 0, 1)), 0);
    drain(2);
    chk(rxw[0] == 8'h00 && rxw[1] == 8'h00, "R8 stored", {rxw[0], rxw[1]}, 0);
  endtask

  task automatic t_half();
    logic [31:0] st;
    miso_inv = 1'b1;
    setup(0, 3, 0, 0, 0, 1, 0);
    chk(mosi_oe == 1'b0, "R9 oe low in receive", 32'(mosi_oe), 0);
    run(1, 1'b0, st);
    chk(st[4] == 1'b1 && oe_high_seen == 0, "R9 received", st, 32'h10);
    drain(1);
    txw[0] = 8'h96;
    setup(0, 3, 0, 0, 0, 1, 32'h10);
    chk(mosi_oe == 1'b1, "R9 oe high in transmit", 32'(mosi_oe), 1);
    run(1, 1'b1, st);
    chk(st[4] == 1'b0 && bit_errs(1, 0, 0) == 0, "R9 transmit only", st, 32'h1);
  endtask

  task automatic t_suspend();
    logic [31:0] st;
    txw[0] = 8'h11; txw[1] = 8'h22; txw[2] = 8'h33;
    miso_inv = 1'b0;
    setup(1, 1, 0, 0, 0, 3, 0);
    for (int i = 0; i < 3; i++) wr(3'd5, 32'(txw[i]));
    wr(3'd0, ctrl_base | 32'h2);
    wr(3'd0, ctrl_base | 32'h4);
    wait_stop(st);
    chk(st[3] == 1'b1 && st[6] == 1'b0 && st[0] == 1'b0, "R10 suspended", st, 32'h8);
    chk(cap_n == 8, "R10 frame boundary", 32'(cap_n), 8);
    wr(3'd4, 32'h8);
    rd(3'd3, st); chk(st[3] == 1'b0, "R13 suspend cleared", st, 0);
    wr(3'd0, ctrl_base | 32'h2);
    wait_stop(st);
    chk(st[0] == 1'b1 && cap_n == 24, "R10 resume finishes", 32'(cap_n), 24);
    chk(bit_errs(3, 0, 0) == 0, "R10 data intact", 32'(bit_errs(3, 0, 0)), 0);
  endtask

  task automatic t_auto();
    logic [31:0] st;
    miso_inv = 1'b0;
    setup(0, 2, 0, 0, 0, 6, 32'h8);
    run(6, 1'b0, st);
    chk(st[3] == 1'b1 && cap_n == 32, "R11 auto suspend when full", 32'(cap_n), 32);
    chk(st[2] == 1'b0, "R11 no overrun with auto", st, 0);
    drain(4);
    chk(rxw[3] == 8'hFF, "R11 kept data", 32'(rxw[3]), 32'hFF);
    wr(3'd4, 32'h8);
    run(6, 1'b0, st);
    chk(st[0] == 1'b1 && cap_n == 48, "R11 resume to end", 32'(cap_n), 48);
    drain(2);
    setup(0, 2, 0, 0, 0, 6, 0);
    run(6, 1'b0, st);
    chk(st[0] == 1'b1 && st[2] == 1'b1, "R11 overrun without auto", st, 32'h5);
    drain(4);
    rd(3'd3, st); chk(st[4] == 1'b0, "R11 extra frames dropped", st, 0);
    wr(3'd4, 32'hF);
    rd(3'd3, st); chk(st[3:0] == 4'h0, "R13 all flags cleared", st, 0);
  endtask

  task automatic t_txfill();
    logic [31:0] st;
    setup(0, 1, 0, 0, 0, 3, 0);
    wr(3'd5, 32'h1); wr(3'd5, 32'h2);
    rd(3'd3, st); chk(st[1] == 1'b0, "R12 not yet filled", st, 0);
    wr(3'd5, 32'h3);
    rd(3'd3, st); chk(st[1] == 1'b1, "R12 filled", st, 32'h2);
    wr(3'd4, 32'h2);
    rd(3'd3, st); chk(st[1] == 1'b0, "R13 filled cleared", st, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0; miso_inv = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_disabled();
    t_cfg_lock();
    t_duplex(1, 0, 0, 0);
    t_duplex(2, 1, 1, 1);
    t_duplex(3, 0, 1, 0);
    t_duplex(0, 1, 0, 1);
    t_txonly();
    t_rxonly();
    t_half();
    t_suspend();
    t_auto();
    t_txfill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule